// File: doc/BRIEF.md
# Banked Inter-Core Interrupt Register Controller

This block gives each of a parameterised number of processor cores its own bank of interrupt registers and a one-line interrupt output. Each bank has a pending-status word, an enable mask, write-only set and clear ports, and a small array of 32-bit mailbox words. Every request on the 32-bit register port carries the ID of the requesting core. That ID decides which bank the access reaches, so all cores use the same offsets and each one sees only its own registers.

A core raises an interrupt in another core by writing a send word. The send word holds a destination core ID and a vector number. The controller routes it as a set of the single status bit (1 << vector) in the destination bank. The interrupt output has asymmetric rules. It rises when a set leaves (status AND enable) nonzero. It falls only when a clear empties status while the enable mask is nonzero. No other event changes it. Every accepted request gets a registered response one cycle later, with read data and an error flag.

Top module: `ipi_bank_ctrl`

## Requirements
- R1: A synchronous active-high reset drives every interrupt output low and clears status, enable and all mailbox words, so they read back as zero.
- R2: `req_ready` is always high. Every request with `req_valid` high produces exactly one `rsp_valid` pulse on the following cycle, and no pulse appears without a request. Write responses and error responses carry zero data.
- R3: `req_core` selects the bank. An access made with one core ID never changes or reveals another core's status, enable, mailbox or interrupt.
- R4: The enable word at offset 0x04 reads back the last value written. Writing it never changes the interrupt output.
- R5: The status word at offset 0x00 is read-only. A write to it leaves all state unchanged and returns `rsp_err` = 1.
- R6: A write to offset 0x08 ORs the data into status. The interrupt goes high if the new status AND enable is nonzero, and otherwise keeps its value. Offset 0x08 reads as zero.
- R7: A write to offset 0x0C clears the written bits of status. The interrupt goes low only if the new status is zero and enable is nonzero, and otherwise keeps its value. Offset 0x0C reads as zero.
- R8: Offsets 0x20 to 0x3C hold eight mailbox words per core, at word index (offset - 0x20) >> 2. Each word is readable and writable.
- R9: A write to offset 0x40 takes the destination core ID from data bits 25:16 and the vector from bits 4:0. It sets status bit (1 << vector) of the destination bank under the rule of R6 and responds OK. Offset 0x40 reads as zero.
- R10: A send whose destination ID is NUM_CORES or greater responds with `rsp_err` = 1 and changes no state.
- R11: Only address bits 7:2 are decoded, so bits 1:0 are ignored. Offsets 0x10 to 0x1C, 0x44 and 0x48 to 0xFC read as zero and ignore writes, both with an OK response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_core | input | CID_W | ID of the requesting core; selects the bank |
| req_addr | input | 8 | Byte offset within the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response pulse, one cycle after the request |
| rsp_err | output | 1 | Error response |
| rsp_rdata | output | 32 | Read data |
| irq_o | output | NUM_CORES | One interrupt line per core |

## Verification
The assertions assume that `req_core` is always below NUM_CORES and that the requester presents at most one request per cycle. They also assume reset is held for at least one clock before the first request. The stimulus draws requester IDs only from the valid range and drops `req_valid` after each single-cycle request. Destination IDs inside send words are deliberately allowed to run past the last core, and address bits 1:0 are randomised, so that the error and ignore paths stay exercised.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
    localparam int DATA_W         = 32;
    localparam int MBOX_WORDS     = 8;
    localparam int MBOX_IDX_W     = $clog2(MBOX_WORDS);
    localparam int WORD_W         = 6;   // address bits 7:2
    // word offsets (byte offset >> 2)
    localparam int W_STATUS       = 0;
    localparam int W_ENABLE       = 1;
    localparam int W_SET          = 2;
    localparam int W_CLEAR        = 3;
    localparam int W_MBOX_BASE    = 8;
    localparam int W_SEND         = W_MBOX_BASE + MBOX_WORDS;
    // send word fields
    localparam int SEND_TGT_LSB   = 16;
    localparam int SEND_TGT_W     = 10;
    localparam int SEND_VEC_W     = 5;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_ENABLE,
        SEL_SET,
        SEL_CLEAR,
        SEL_MBOX,
        SEL_SEND
    } ipi_sel_e;
endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
    import ipi_pkg::*;
(
    input  logic [WORD_W-1:0]     word_i,
    output ipi_sel_e              sel_o,
    output logic [MBOX_IDX_W-1:0] mbox_idx_o
);
    logic [WORD_W-1:0] rel;

    always_comb begin
        rel        = word_i - WORD_W'(W_MBOX_BASE);
        mbox_idx_o = rel[MBOX_IDX_W-1:0];
        sel_o      = SEL_NONE;
        if (word_i == WORD_W'(W_STATUS))      sel_o = SEL_STATUS;
        else if (word_i == WORD_W'(W_ENABLE)) sel_o = SEL_ENABLE;
        else if (word_i == WORD_W'(W_SET))    sel_o = SEL_SET;
        else if (word_i == WORD_W'(W_CLEAR))  sel_o = SEL_CLEAR;
        else if (word_i >= WORD_W'(W_MBOX_BASE) && word_i < WORD_W'(W_SEND))
            sel_o = SEL_MBOX;
        else if (word_i == WORD_W'(W_SEND))   sel_o = SEL_SEND;
    end
endmodule

// File: rtl/ipi_core_bank.sv
module ipi_core_bank
    import ipi_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  en_we_i,
    input  logic                  set_we_i,
    input  logic                  clr_we_i,
    input  logic                  mbox_we_i,
    input  logic [MBOX_IDX_W-1:0] mbox_idx_i,
    input  logic [DATA_W-1:0]     wdata_i,
    output logic [DATA_W-1:0]     status_o,
    output logic [DATA_W-1:0]     enable_o,
    output logic [DATA_W-1:0]     mbox_rd_o,
    output logic                  irq_o
);
    typedef struct packed {
        logic [DATA_W-1:0]                 status;
        logic [DATA_W-1:0]                 enable;
        logic                              irq;
        logic [MBOX_WORDS-1:0][DATA_W-1:0] mbox;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_we_i) begin
            st_d.enable = wdata_i;
        end
        if (set_we_i) begin
            st_d.status = st_q.status | wdata_i;
            if ((st_d.status & st_q.enable) != '0) st_d.irq = 1'b1;
        end
        if (clr_we_i) begin
            st_d.status = st_q.status & ~wdata_i;
            if (st_d.status == '0 && st_q.enable != '0) st_d.irq = 1'b0;
        end
        if (mbox_we_i) begin
            st_d.mbox[mbox_idx_i] = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign status_o  = st_q.status;
    assign enable_o  = st_q.enable;
    assign mbox_rd_o = st_q.mbox[mbox_idx_i];
    assign irq_o     = st_q.irq;
endmodule

// File: rtl/ipi_bank_ctrl.sv
module ipi_bank_ctrl
    import ipi_pkg::*;
#(
    parameter int NUM_CORES = 4,
    localparam int CID_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [CID_W-1:0]     req_core,
    input  logic [7:0]           req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 rsp_valid,
    output logic                 rsp_err,
    output logic [DATA_W-1:0]    rsp_rdata,
    output logic [NUM_CORES-1:0] irq_o
);
    typedef struct packed {
        logic              valid;
        logic              err;
        logic [DATA_W-1:0] rdata;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    ipi_sel_e              sel;
    logic [MBOX_IDX_W-1:0] mbox_idx;
    logic [1:0]            unused_addr_lsb;
    logic [SEND_TGT_W-1:0] tgt;
    logic                  tgt_ok;
    logic [DATA_W-1:0]     vec_bit;
    logic                  wr_acc;

    logic [DATA_W-1:0] status_a [NUM_CORES];
    logic [DATA_W-1:0] enable_a [NUM_CORES];
    logic [DATA_W-1:0] mbox_a   [NUM_CORES];
    logic [NUM_CORES*DATA_W-1:0] status_flat;
    logic [NUM_CORES*DATA_W-1:0] enable_flat;

    assign req_ready       = 1'b1;
    assign unused_addr_lsb = req_addr[1:0];
    assign wr_acc          = req_valid && req_write;
    assign tgt             = req_wdata[SEND_TGT_LSB +: SEND_TGT_W];
    assign tgt_ok          = 32'(tgt) < 32'(NUM_CORES);
    assign vec_bit         = DATA_W'(1) << req_wdata[SEND_VEC_W-1:0];

    ipi_decode u_decode (
        .word_i     (req_addr[7:2]),
        .sel_o      (sel),
        .mbox_idx_o (mbox_idx)
    );

    for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
        logic own;
        logic set_we;
        logic send_hit;
        assign own      = wr_acc && (32'(req_core) == i);
        assign send_hit = wr_acc && (sel == SEL_SEND) && tgt_ok && (32'(tgt) == i);
        assign set_we   = (own && sel == SEL_SET) || send_hit;

        ipi_core_bank u_bank (
            .clk        (clk),
            .rst        (rst),
            .en_we_i    (own && sel == SEL_ENABLE),
            .set_we_i   (set_we),
            .clr_we_i   (own && sel == SEL_CLEAR),
            .mbox_we_i  (own && sel == SEL_MBOX),
            .mbox_idx_i (mbox_idx),
            .wdata_i    (send_hit ? vec_bit : req_wdata),
            .status_o   (status_a[i]),
            .enable_o   (enable_a[i]),
            .mbox_rd_o  (mbox_a[i]),
            .irq_o      (irq_o[i])
        );

        assign status_flat[i*DATA_W +: DATA_W] = status_a[i];
        assign enable_flat[i*DATA_W +: DATA_W] = enable_a[i];
    end

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        if (wr_acc) begin
            rsp_d.err = (sel == SEL_STATUS) || (sel == SEL_SEND && !tgt_ok);
        end else if (req_valid && 32'(req_core) < 32'(NUM_CORES)) begin
            case (sel)
                SEL_STATUS: rsp_d.rdata = status_a[req_core];
                SEL_ENABLE: rsp_d.rdata = enable_a[req_core];
                SEL_MBOX:   rsp_d.rdata = mbox_a[req_core];
                default:    rsp_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rsp_q <= '0;
        else     rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_err   = rsp_q.err;
    assign rsp_rdata = rsp_q.rdata;
endmodule

// File: rtl/ipi_bank_checker.sv
module ipi_bank_checker
    import ipi_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        req_valid,
    input logic                        req_write,
    input logic [7:0]                  req_addr,
    input logic                        rsp_valid,
    input logic                        rsp_err,
    input logic [DATA_W-1:0]           rsp_rdata,
    input logic [NUM_CORES-1:0]        irq_o,
    input logic [NUM_CORES*DATA_W-1:0] status_flat,
    input logic [NUM_CORES*DATA_W-1:0] enable_flat
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (irq_o == '0) && !rsp_valid);

    assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    assert_status_wr_err_R5: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_write && req_addr[7:2] == 6'(W_STATUS) |=> rsp_err);

    // covers the set port (R6) and the clear port (R7)
    assert_setclr_rd_zero_R6: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_write &&
        (req_addr[7:2] == 6'(W_SET) || req_addr[7:2] == 6'(W_CLEAR))
        |=> rsp_rdata == '0);

    assert_irq_idle_stable_R4: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(irq_o));

    assert_enable_wr_no_irq_R4: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_write && req_addr[7:2] == 6'(W_ENABLE) |=> $stable(irq_o));

    for (genvar i = 0; i < NUM_CORES; i++) begin : g_chk
        assert_irq_rise_R6: assert property (@(posedge clk) disable iff (rst)
            $rose(irq_o[i]) |->
            (status_flat[i*DATA_W +: DATA_W] & enable_flat[i*DATA_W +: DATA_W]) != '0);

        assert_irq_fall_R7: assert property (@(posedge clk) disable iff (rst)
            $fell(irq_o[i]) |->
            status_flat[i*DATA_W +: DATA_W] == '0 && enable_flat[i*DATA_W +: DATA_W] != '0);
    end
endmodule

bind ipi_bank_ctrl ipi_bank_checker #(.NUM_CORES(NUM_CORES)) u_checker (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .rsp_rdata   (rsp_rdata),
    .irq_o       (irq_o),
    .status_flat (status_flat),
    .enable_flat (enable_flat)
);

// File: tb/ipi_bank_ctrl_tb.sv
module ipi_bank_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 4;
    localparam int CW         = 2;
    localparam int RAND_OPS   = 3000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [CW-1:0] req_core = '0;
    logic [7:0]    req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid;
    logic          rsp_err;
    logic [31:0]   rsp_rdata;
    logic [N-1:0]  irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] m_status [N];
    logic [31:0] m_en     [N];
    logic [31:0] m_mbox   [N][8];
    logic [N-1:0] m_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    ipi_bank_ctrl #(.NUM_CORES(N)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_core(req_core), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic void model_set(int c, logic [31:0] v);
        m_status[c] = m_status[c] | v;
        if ((m_status[c] & m_en[c]) != 0) m_irq[c] = 1'b1;
    endfunction

    function automatic void model_clear(int c, logic [31:0] v);
        m_status[c] = m_status[c] & ~v;
        if (m_status[c] == 0 && m_en[c] != 0) m_irq[c] = 1'b0;
    endfunction

    // one request; expected values from the requirement model
    task automatic access(input bit wr, input int core, input logic [7:0] addr,
                          input logic [31:0] wd);
        int          w;
        int          tgt;
        logic        e_err;
        logic [31:0] e_rd;
        string       tag;
        w = int'(addr[7:2]);
        e_err = 1'b0;
        e_rd  = '0;
        if (w == 0)                tag = wr ? "R5" : "R1/R6 status read";
        else if (w == 1)           tag = "R4";
        else if (w == 2)           tag = "R6";
        else if (w == 3)           tag = "R7";
        else if (w >= 8 && w < 16) tag = "R8";
        else if (w == 16)          tag = (wr && int'(wd[25:16]) >= N) ? "R10" : "R9";
        else                       tag = "R11";
        if (wr) begin
            if (w == 0) e_err = 1'b1;
            else if (w == 1) m_en[core] = wd;
            else if (w == 2) model_set(core, wd);
            else if (w == 3) model_clear(core, wd);
            else if (w >= 8 && w < 16) m_mbox[core][w-8] = wd;
            else if (w == 16) begin
                tgt = int'(wd[25:16]);
                if (tgt < N) model_set(tgt, 32'(1) << wd[4:0]);
                else e_err = 1'b1;
            end
        end else begin
            if (w == 0) e_rd = m_status[core];
            else if (w == 1) e_rd = m_en[core];
            else if (w >= 8 && w < 16) e_rd = m_mbox[core][w-8];
        end
        req_valid = 1'b1;
        req_write = wr;
        req_core  = CW'(core);
        req_addr  = addr;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 rsp_valid", 32'(rsp_valid), 32'd1);
        check({tag, " err"}, 32'(rsp_err), 32'(e_err));
        check({tag, " rdata"}, rsp_rdata, e_rd);
        check({tag, " irq"}, 32'(irq_o), 32'(m_irq));
    endtask

    function automatic logic [7:0] pick_addr();
        int k;
        k = $urandom_range(0, 15);
        case (k)
            0, 1:   pick_addr = 8'h00;
            2, 3:   pick_addr = 8'h04;
            4, 5:   pick_addr = 8'h08;
            6, 7:   pick_addr = 8'h0C;
            8, 9:   pick_addr = 8'h20 + 8'(4 * $urandom_range(0, 7));
            10, 11, 12: pick_addr = 8'h40;
            13:     pick_addr = 8'h10 + 8'(4 * $urandom_range(0, 3));
            14:     pick_addr = 8'h44;
            default: pick_addr = 8'h48 + 8'(4 * $urandom_range(0, 45));
        endcase
        pick_addr = pick_addr | 8'($urandom_range(0, 3));
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240605));
        for (int c = 0; c < N; c++) begin
            m_status[c] = '0;
            m_en[c] = '0;
            for (int j = 0; j < 8; j++) m_mbox[c][j] = '0;
        end
        m_irq = '0;
        repeat (3) @(negedge clk);
        check("R1 irq in reset", 32'(irq_o), 32'd0);
        check("R1 rsp_valid in reset", 32'(rsp_valid), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R2 idle no rsp", 32'(rsp_valid), 32'd0);

        // R1: reset values
        for (int c = 0; c < N; c++) begin
            access(0, c, 8'h00, '0);
            access(0, c, 8'h04, '0);
            access(0, c, 8'h3C, '0);
        end
        // R4/R6/R7: asymmetric interrupt rules on core 1
        access(1, 1, 8'h04, 32'h5);
        access(0, 1, 8'h04, '0);
        access(1, 1, 8'h08, 32'h2);       // masked: irq stays low
        access(1, 1, 8'h08, 32'h4);       // raise
        access(0, 1, 8'h08, '0);
        access(1, 1, 8'h04, 32'h0);       // R4: irq stays high
        access(1, 1, 8'h0C, 32'h6);       // R7: enable zero, irq stays high
        access(0, 1, 8'h00, '0);
        access(1, 1, 8'h04, 32'h1);       // R4: still high
        access(1, 1, 8'h0C, 32'h0);       // R7: empty + enabled: lower
        access(0, 1, 8'h0C, '0);
        // R5: status is read-only
        access(1, 1, 8'h00, 32'hFFFF_FFFF);
        access(0, 1, 8'h00, '0);
        // R9: send from core 2 to core 3, vector 31, junk high bits
        access(1, 3, 8'h04, 32'h8000_0000);
        access(1, 2, 8'h40, 32'hFC03_00FF);
        access(0, 3, 8'h00, '0);
        access(0, 2, 8'h40, '0);
        // R10: destinations out of range
        access(1, 0, 8'h40, 32'h0004_0001);
        access(1, 0, 8'h40, 32'h03FF_0003);
        access(0, 0, 8'h00, '0);
        // R3/R8: mailbox banking
        access(1, 0, 8'h3C, 32'hCAFE_F00D);
        access(1, 0, 8'h20, 32'h1234_5678);
        access(0, 1, 8'h3C, '0);
        check("R3 other bank untouched", rsp_rdata, 32'h0);
        access(0, 0, 8'h3C, '0);
        access(0, 0, 8'h23, '0);
        // R11: holes and address low bits
        access(1, 0, 8'h10, 32'hFFFF_FFFF);
        access(0, 0, 8'h10, '0);
        access(1, 0, 8'h44, 32'hFFFF_FFFF);
        access(1, 0, 8'hFC, 32'hFFFF_FFFF);
        access(0, 0, 8'hFF, '0);
        access(0, 0, 8'h05, '0);
        @(negedge clk);
        check("R2 idle no rsp", 32'(rsp_valid), 32'd0);

        // mixed random traffic
        for (int n = 0; n < RAND_OPS; n++) begin
            logic [7:0]  a;
            logic [31:0] d;
            a = pick_addr();
            d = $urandom;
            if (a[7:2] == 6'd2 || a[7:2] == 6'd3) d = d & $urandom & $urandom;
            if (a[7:2] == 6'd1 && $urandom_range(0, 3) == 0) d = '0;
            if (a[7:2] == 6'd16) d[25:16] = 10'($urandom_range(0, N + 1));
            access($urandom_range(0, 1) == 1, $urandom_range(0, N - 1), a, d);
            if ($urandom_range(0, 7) == 0) begin
                @(negedge clk);
                check("R2 idle no rsp", 32'(rsp_valid), 32'd0);
                check("R4 irq stable when idle", 32'(irq_o), 32'(m_irq));
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule